// File: doc/BRIEF.md
# Autoranging Channel Measurement Sequencer

This block steers a single analog front end that feeds one ADC. Through the channel-select output it picks between line voltage and load current. Through the gain-select output it picks high or low amplifier gain. It counts AC periods in windows of nine. At the end of every window the channel changes over. The first period of each window only lets the front end settle and resynchronise, and its values are thrown away. Over the other eight periods the block sums the positive and negative peak amplitudes, and the tick delay from the reference voltage peak to the positive peak, that neighbouring blocks report.

A voltage window and the current window after it make one result set. The set holds the averaged voltage amplitude, the averaged current amplitude and the phase shift. The current word carries a range flag that records which gain was in use. The phase shift is the voltage delay minus the current delay. The three result words update together with a one-cycle valid pulse, once every 18 AC periods. A busy flag lets a reader wait until the sums are no longer moving.

The voltage channel is always measured in high gain. The current range moves by hysteresis on the window average. A change of range takes effect at the next current window, and that window opens with a discarded settling period.

Top module: `chan_meas_seq`

## Requirements
- R1: After reset the outputs are as follows. chan_sel_o is 0 (voltage), gain_hi_o is 1, and all result words are 0. res_valid_o is 0 and busy_o is 0.
- R2: chan_sel_o (0 = voltage, 1 = current) inverts on the clock edge that samples every ninth prd_end_i strobe, counted from reset.
- R3: Peak and delay values presented with the first strobe of a window have no effect on any result.
- R4: The amplitude average is the sum of (pos_peak_i + neg_peak_i) over the eight accumulating periods, shifted right by 4.
- R5: The delay average is the sum of dly_i over the eight accumulating periods, shifted right by 3. phase_o, a two's complement value, equals the voltage delay average minus the current delay average.
- R6: gain_hi_o is 1 for the whole of every voltage window.
- R7: The current range resets to low gain. After a current window whose amplitude average is below LO_THR it becomes high. After one whose average is above HI_THR it becomes low. Otherwise it holds. gain_hi_o shows this range during current windows.
- R8: Bit 15 of cur_res_o is 1 when the window was measured in high gain. Bits 14:0 hold the zero-extended amplitude average. volt_res_o is the zero-extended voltage amplitude average.
- R9: The three result words change only together, on the cycle res_valid_o is high. res_valid_o is a single-cycle pulse, two clocks after the strobe that closes a current window.
- R10: busy_o is 1 from the strobe that ends a window's discarded period up to the strobe that closes the window. It is 0 otherwise, and it is always 0 while res_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prd_end_i | input | 1 | One-cycle strobe at the end of the negative half-cycle that closes an AC period |
| pos_peak_i | input | 12 | Positive peak ADC code of the period just ended |
| neg_peak_i | input | 12 | Negative peak ADC code of the period just ended |
| dly_i | input | 16 | Ticks from the reference voltage peak to the positive peak |
| chan_sel_o | output | 1 | 0 selects line voltage, 1 selects load current |
| gain_hi_o | output | 1 | 1 selects high amplifier gain |
| busy_o | output | 1 | Sums are being built |
| res_valid_o | output | 1 | One-cycle pulse when a new result set appears |
| volt_res_o | output | 16 | Voltage amplitude average |
| cur_res_o | output | 16 | Range flag in bit 15, current amplitude in bits 14:0 |
| phase_o | output | 17 | Voltage delay average minus current delay average, signed |

## Verification
On every cycle the assertions check the following. The channel flips only at a window's closing strobe. The current range changes only after a current window, and it rises only when the average is below the low threshold. The valid pulse lasts one cycle and never meets busy. Result words never move without the valid pulse. Only the scenarios can show the numbers themselves. These are the discarded settling values, the averages with their truncation, the sign of the phase, the range flag lagging one window behind the hysteresis decision, and the hold between the two thresholds.

// File: rtl/cms_pkg.sv
package cms_pkg;
    typedef enum logic {
        CH_VOLT = 1'b0,
        CH_CUR  = 1'b1
    } chan_e;
endpackage

// File: rtl/cms_window_ctr.sv
module cms_window_ctr
    import cms_pkg::*;
#(
    parameter int PER_WIN = 9
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  prd_end_i,
    output chan_e chan_o,
    output logic  acc_en_o,
    output logic  win_last_o,
    output logic  busy_o
);
    localparam int CW = $clog2(PER_WIN);
    localparam logic [CW-1:0] LAST = CW'(PER_WIN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        chan_e         chan;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (prd_end_i) begin
            if (win_q.cnt == LAST) begin
                win_d.cnt  = '0;
                win_d.chan = (win_q.chan == CH_VOLT) ? CH_CUR : CH_VOLT;
            end else begin
                win_d.cnt = win_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q.cnt  <= '0;
            win_q.chan <= CH_VOLT;
        end else begin
            win_q <= win_d;
        end
    end

    assign chan_o     = win_q.chan;
    assign acc_en_o   = prd_end_i && (win_q.cnt != '0);
    assign win_last_o = prd_end_i && (win_q.cnt == LAST);
    assign busy_o     = (win_q.cnt != '0);

    // R2: the channel only flips on the strobe that closes a window
    assert_chan_flip_at_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win_q.chan) |-> $past(win_last_o));
endmodule

// File: rtl/cms_accum.sv
module cms_accum
    import cms_pkg::*;
#(
    parameter int ADC_W    = 12,
    parameter int DLY_W    = 16,
    parameter int AVG_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en_i,
    input  logic             last_i,
    input  chan_e            chan_i,
    input  logic [ADC_W-1:0] pos_i,
    input  logic [ADC_W-1:0] neg_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             done_o,
    output chan_e            done_chan_o,
    output logic [ADC_W-1:0] amp_avg_o,
    output logic [DLY_W-1:0] dly_avg_o
);
    localparam int AS_W = ADC_W + AVG_LOG2 + 1;
    localparam int DS_W = DLY_W + AVG_LOG2;

    typedef struct packed {
        logic [AS_W-1:0]  amp_sum;
        logic [DS_W-1:0]  dly_sum;
        logic             done;
        chan_e            chan;
        logic [ADC_W-1:0] amp_avg;
        logic [DLY_W-1:0] dly_avg;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [AS_W-1:0] amp_next;
    logic [DS_W-1:0] dly_next;

    always_comb begin
        amp_next   = acc_q.amp_sum + AS_W'(pos_i) + AS_W'(neg_i);
        dly_next   = acc_q.dly_sum + DS_W'(dly_i);
        acc_d      = acc_q;
        acc_d.done = 1'b0;
        if (acc_en_i) begin
            if (last_i) begin
                acc_d.amp_avg = ADC_W'(amp_next >> (AVG_LOG2 + 1));
                acc_d.dly_avg = DLY_W'(dly_next >> AVG_LOG2);
                acc_d.chan    = chan_i;
                acc_d.done    = 1'b1;
                acc_d.amp_sum = '0;
                acc_d.dly_sum = '0;
            end else begin
                acc_d.amp_sum = amp_next;
                acc_d.dly_sum = dly_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            acc_q.chan <= CH_VOLT;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign done_o      = acc_q.done;
    assign done_chan_o = acc_q.chan;
    assign amp_avg_o   = acc_q.amp_avg;
    assign dly_avg_o   = acc_q.dly_avg;

    // R9: a window completion is flagged for exactly one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/cms_gain_ctl.sv
module cms_gain_ctl
    import cms_pkg::*;
#(
    parameter int ADC_W  = 12,
    parameter int LO_THR = 273,
    parameter int HI_THR = 1589
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  chan_e            done_chan_i,
    input  logic [ADC_W-1:0] amp_avg_i,
    output logic             gain_hi_o
);
    localparam logic [ADC_W-1:0] LO = ADC_W'(LO_THR);
    localparam logic [ADC_W-1:0] HI = ADC_W'(HI_THR);

    logic gain_d, gain_q;

    always_comb begin
        gain_d = gain_q;
        if (done_i && done_chan_i == CH_CUR) begin
            if (!gain_q && amp_avg_i < LO)
                gain_d = 1'b1;
            else if (gain_q && amp_avg_i > HI)
                gain_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gain_q <= 1'b0;
        else        gain_q <= gain_d;
    end

    assign gain_hi_o = gain_q;

    // R7: range moves only after a completed current window
    assert_gain_moves_after_cur_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_q) |-> $past(done_i && done_chan_i == CH_CUR));
    // R7: entering high gain needs a small average
    assert_gain_rise_low_amp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gain_q) |-> ($past(amp_avg_i) < LO));
endmodule

// File: rtl/chan_meas_seq.sv
module chan_meas_seq
    import cms_pkg::*;
#(
    parameter int ADC_W    = 12,
    parameter int DLY_W    = 16,
    parameter int RES_W    = 16,
    parameter int AVG_LOG2 = 3,
    parameter int SETTLE   = 1,
    parameter int LO_THR   = 273,
    parameter int HI_THR   = 1589
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prd_end_i,
    input  logic [ADC_W-1:0]   pos_peak_i,
    input  logic [ADC_W-1:0]   neg_peak_i,
    input  logic [DLY_W-1:0]   dly_i,
    output logic               chan_sel_o,
    output logic               gain_hi_o,
    output logic               busy_o,
    output logic               res_valid_o,
    output logic [RES_W-1:0]   volt_res_o,
    output logic [RES_W-1:0]   cur_res_o,
    output logic signed [DLY_W:0] phase_o
);
    localparam int PER_WIN = SETTLE + (1 << AVG_LOG2);

    chan_e            chan;
    logic             acc_en, win_last, done, cur_gain;
    chan_e            done_chan;
    logic [ADC_W-1:0] amp_avg;
    logic [DLY_W-1:0] dly_avg;

    cms_window_ctr #(.PER_WIN(PER_WIN)) i_win (
        .clk(clk), .rst_n(rst_n), .prd_end_i(prd_end_i),
        .chan_o(chan), .acc_en_o(acc_en), .win_last_o(win_last), .busy_o(busy_o));

    cms_accum #(.ADC_W(ADC_W), .DLY_W(DLY_W), .AVG_LOG2(AVG_LOG2)) i_acc (
        .clk(clk), .rst_n(rst_n), .acc_en_i(acc_en), .last_i(win_last),
        .chan_i(chan), .pos_i(pos_peak_i), .neg_i(neg_peak_i), .dly_i(dly_i),
        .done_o(done), .done_chan_o(done_chan), .amp_avg_o(amp_avg), .dly_avg_o(dly_avg));

    cms_gain_ctl #(.ADC_W(ADC_W), .LO_THR(LO_THR), .HI_THR(HI_THR)) i_gain (
        .clk(clk), .rst_n(rst_n), .done_i(done), .done_chan_i(done_chan),
        .amp_avg_i(amp_avg), .gain_hi_o(cur_gain));

    typedef struct packed {
        logic [ADC_W-1:0]   v_amp;
        logic [DLY_W-1:0]   v_dly;
        logic               v_seen;
        logic [RES_W-1:0]   volt;
        logic [RES_W-1:0]   cur;
        logic signed [DLY_W:0] phase;
        logic               valid;
    } res_t;

    res_t res_d, res_q;
    logic [RES_W-1:0] cur_word;

    always_comb begin
        cur_word            = RES_W'(amp_avg);
        cur_word[RES_W-1]   = cur_gain;
        res_d               = res_q;
        res_d.valid         = 1'b0;
        if (done && done_chan == CH_VOLT) begin
            res_d.v_amp  = amp_avg;
            res_d.v_dly  = dly_avg;
            res_d.v_seen = 1'b1;
        end else if (done && done_chan == CH_CUR && res_q.v_seen) begin
            res_d.volt   = RES_W'(res_q.v_amp);
            res_d.cur    = cur_word;
            res_d.phase  = $signed({1'b0, res_q.v_dly}) - $signed({1'b0, dly_avg});
            res_d.valid  = 1'b1;
            res_d.v_seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign chan_sel_o  = chan;
    assign gain_hi_o   = (chan == CH_VOLT) ? 1'b1 : cur_gain;
    assign res_valid_o = res_q.valid;
    assign volt_res_o  = res_q.volt;
    assign cur_res_o   = res_q.cur;
    assign phase_o     = res_q.phase;

    // R9: result words only move with the valid pulse
    assert_results_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(volt_res_o) || !$stable(cur_res_o) || !$stable(phase_o)) |-> res_valid_o);
    // R9: the valid pulse lasts one cycle
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    // R10: no result is published while sums are being built
    assert_valid_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !busy_o);
endmodule

// File: tb/test_chan_meas_seq.sv
module test_chan_meas_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prd_end_i = 1'b0;
    logic [11:0] pos_peak_i = '0;
    logic [11:0] neg_peak_i = '0;
    logic [15:0] dly_i = '0;
    logic chan_sel_o, gain_hi_o, busy_o, res_valid_o;
    logic [15:0] volt_res_o, cur_res_o;
    logic signed [16:0] phase_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int valid_seen = 0;
    bit done_flag = 1'b0;
    bit exp_gain = 1'b0;

    typedef struct {
        logic [15:0] v;
        logic [15:0] c;
        int          ph;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    chan_meas_seq i_chan_meas_seq (
        .clk(clk), .rst_n(rst_n), .prd_end_i(prd_end_i),
        .pos_peak_i(pos_peak_i), .neg_peak_i(neg_peak_i), .dly_i(dly_i),
        .chan_sel_o(chan_sel_o), .gain_hi_o(gain_hi_o), .busy_o(busy_o),
        .res_valid_o(res_valid_o), .volt_res_o(volt_res_o), .cur_res_o(cur_res_o),
        .phase_o(phase_o));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // monitor: pop expected set on every valid pulse
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            valid_seen++;
            if (sb_q.size() == 0) begin
                check("R9 unexpected valid", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R4 R8 volt_res", int'(volt_res_o), int'(e.v));
                check("R7 R8 cur_res", int'(cur_res_o), int'(e.c));
                check("R5 phase", int'(phase_o), e.ph);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            finish_run();
        end
    end

    task automatic strobe(input int pos, input int neg, input int dly);
        @(negedge clk);
        pos_peak_i = 12'(pos);
        neg_peak_i = 12'(neg);
        dly_i      = 16'(dly);
        prd_end_i  = 1'b1;
        @(negedge clk);
        prd_end_i  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // one window: discarded period with junk values, then 8 periods
    task automatic run_window(input bit is_cur, input int base, input int dbase);
        check("R2 chan at window start", int'(chan_sel_o), int'(is_cur));
        strobe(4095, 4095, 65535);   // R3: junk must be ignored
        check("R10 busy after settle", int'(busy_o), 1);
        if (is_cur) check("R7 gain in current window", int'(gain_hi_o), int'(exp_gain));
        else        check("R6 high gain in voltage window", int'(gain_hi_o), 1);
        for (int k = 1; k <= 8; k++) strobe(base + k, base, dbase + k);
        check("R10 busy after window", int'(busy_o), 0);
        check("R2 chan flipped", int'(chan_sel_o), int'(!is_cur));
    endtask

    task automatic run_pair(input int vb, input int vd, input int cb, input int cd);
        int vs, ds, cs, cds, v_amp, v_dly, c_amp, c_dly;
        exp_t e;
        vs = 0; ds = 0; cs = 0; cds = 0;
        for (int k = 1; k <= 8; k++) begin
            vs += (vb + k) + vb;  ds  += vd + k;
            cs += (cb + k) + cb;  cds += cd + k;
        end
        v_amp = vs >> 4;  v_dly = ds >> 3;
        c_amp = cs >> 4;  c_dly = cds >> 3;
        e.v  = 16'(v_amp);
        e.c  = 16'(c_amp) | (exp_gain ? 16'h8000 : 16'h0000);
        e.ph = v_dly - c_dly;
        sb_q.push_back(e);
        run_window(1'b0, vb, vd);
        run_window(1'b1, cb, cd);
        // R7 hysteresis model: LO_THR=273, HI_THR=1589
        if (!exp_gain && c_amp < 273)      exp_gain = 1'b1;
        else if (exp_gain && c_amp > 1589) exp_gain = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 chan reset", int'(chan_sel_o), 0);
        check("R1 gain reset", int'(gain_hi_o), 1);
        check("R1 busy reset", int'(busy_o), 0);
        check("R1 valid reset", int'(res_valid_o), 0);
        check("R1 results reset", int'(volt_res_o | cur_res_o), 0);
        check("R1 phase reset", int'(phase_o), 0);
        run_pair(2000, 300, 1000, 250);   // mid range, low gain holds
        run_pair(1800, 100, 100, 400);    // small current -> switch high
        run_pair(2200, 500, 500, 100);    // high gain, holds between thresholds
        run_pair(1500, 50, 2000, 900);    // large current -> back to low
        run_pair(1700, 200, 1500, 200);   // low gain, zero-ish phase
        repeat (5) @(negedge clk);
        check("R9 result sets published", valid_seen, 5);
        check("R9 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule